// File: doc/BRIEF.md
# Time-Stamped Phasor Measurement Packet Framer

This block sits at a phasor measurement point whose sampling is locked to an absolute time reference. A pulse-per-second input marks each second boundary. A sample strobe arrives 720 times per second, in step with that reference. The block keeps two counters: a 32-bit count of whole seconds since a fixed epoch, which an external time source can load, and an index of the sample within the current second.

Twelve times per second, on the second boundary and after every sixtieth sample, the block takes a snapshot. The snapshot holds the current second count, the sample index, the positive-sequence voltage phasor (real and imaginary parts) and the system frequency. It then sends the snapshot as a compact binary packet, one byte at a time, over a valid/ready byte stream that feeds a serial transmitter. The timestamp is a flat seconds count plus a sample index, so a receiver can line up packets from several sites by comparing two integers.

The block does not buffer packets. If the link is still busy with one packet when the next is due, the new packet is dropped and a sticky overrun flag is raised.

Top module: `phasor_pkt_framer`

## Requirements
- R1: After a synchronous active-low reset, `tx_valid` and `overrun` are 0, the seconds count is 0 and the sample index is 0.
- R2: A rising edge on `pps` (high in a cycle after a cycle in which it was low) does three things: it clears the sample index to 0, it increments the seconds count, and it starts a packet whose first byte is presented with `tx_valid` high in the next cycle. Holding `pps` high starts no further packets.
- R3: Each `smp_stb` pulse advances the sample index by one. A packet starts whenever the index reaches a nonzero multiple of 60, which gives 12 packets per second.
- R4: The sample index saturates at 719. Strobes beyond that are ignored and start no packet until the next `pps` edge.
- R5: A `tset_valid` pulse loads `tset_sec` into the seconds count without starting a packet. When it coincides with a `pps` edge, the loaded value wins over the increment, and the sample index still clears and a packet still starts.
- R6: A packet is 14 bytes long, and every multi-byte field is sent most significant byte first. The bytes are, in order:
  - sync byte 0xA5;
  - 4 bytes of seconds count;
  - 2 bytes of sample index, zero-extended;
  - 2 bytes of phasor real part;
  - 2 bytes of phasor imaginary part;
  - 2 bytes of frequency;
  - 1 byte that is the XOR of the 13 preceding bytes.
- R7: The phasor and frequency inputs are captured in the cycle that starts the packet. Later changes to those inputs do not alter a packet in flight.
- R8: A byte is consumed only in a cycle with `tx_valid` and `tx_ready` both high. While `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R9: A packet due while another is still in flight is dropped entirely, and `overrun` goes high and stays high until reset.
- R10: A `smp_stb` pulse in the same cycle as a `pps` edge is absorbed, so the index is 0 after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pps | input | 1 | Pulse-per-second level from the time reference |
| smp_stb | input | 1 | One-cycle strobe per synchronized sample |
| tset_valid | input | 1 | Load strobe for the seconds count |
| tset_sec | input | 32 | Seconds value to load |
| ph_re | input | 16 | Positive-sequence voltage phasor, real part |
| ph_im | input | 16 | Positive-sequence voltage phasor, imaginary part |
| freq_in | input | 16 | System frequency measurement |
| tx_data | output | 8 | Packet byte |
| tx_valid | output | 1 | Byte on `tx_data` is valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| overrun | output | 1 | Sticky flag, set when a packet was dropped |

## Verification
Faults in the seconds or sample counters surface in the timestamp fields of the very next packet, which starts one cycle after its trigger. A wrong phase counter shifts packet starts away from every sixtieth strobe, and the bench sees this as a packet count or sample field that does not match. A broken byte index or hold path shows as a wrong or shifted byte, or a bad checksum, within the 14 cycles of one packet. A bad overrun decision shows as an extra or missing packet, or a flag value that differs from the expected one, in the first packet period after the collision.

// File: rtl/sphx_pkg.sv
`timescale 1ns/1ps
// Shared constants and the packet snapshot type for the phasor framer.
// Assumes fixed 16-bit measurement fields and a 32-bit seconds count.
package sphx_pkg;
    localparam logic [7:0] SYNC_BYTE = 8'hA5;
    localparam int SEC_W  = 32;
    localparam int FLD_W  = 16;
    localparam int BODY_BYTES = 1 + (SEC_W + 4 * FLD_W) / 8;
    localparam int PKT_BYTES  = BODY_BYTES + 1;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [FLD_W-1:0] smp;
        logic [FLD_W-1:0] re;
        logic [FLD_W-1:0] im;
        logic [FLD_W-1:0] freq;
    } snap_t;
endpackage

// File: rtl/sphx_time_base.sv
`timescale 1ns/1ps
// Keeps the seconds count and the sample index within the second, and
// flags the cycles in which a packet must start (second edge and every
// SMP_PER_PKT samples). Assumes smp_stb is one cycle wide per sample and
// that SMP_PER_SEC fits in 16 bits.
module sphx_time_base #(
    parameter int SMP_PER_SEC = 720,
    parameter int PKT_PER_SEC = 12,
    localparam int SMP_PER_PKT = SMP_PER_SEC / PKT_PER_SEC,
    localparam int CNT_W = $clog2(SMP_PER_SEC),
    localparam int PH_W  = (SMP_PER_PKT > 1) ? $clog2(SMP_PER_PKT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps,
    input  logic             smp_stb,
    input  logic             tset_valid,
    input  logic [31:0]      tset_sec,
    output logic             pps_edge,
    output logic             trig,
    output logic [31:0]      nxt_sec,
    output logic [CNT_W-1:0] nxt_smp,
    output logic [31:0]      sec_q,
    output logic [CNT_W-1:0] smp_q
);
    localparam logic [CNT_W-1:0] SMP_LAST = CNT_W'(SMP_PER_SEC - 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SMP_PER_PKT - 1);

    logic            pps_q;
    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] nxt_ph;

    assign pps_edge = pps & ~pps_q;

    // Next-state of counters and the packet trigger
    always_comb begin
        nxt_sec = sec_q;
        nxt_smp = smp_q;
        nxt_ph  = ph_q;
        trig    = 1'b0;
        if (pps_edge) begin
            nxt_smp = '0;
            nxt_ph  = '0;
            nxt_sec = sec_q + 32'd1;
            trig    = 1'b1;
        end else if (smp_stb && (smp_q != SMP_LAST)) begin
            nxt_smp = smp_q + CNT_W'(1);
            if (ph_q == PH_LAST) begin
                nxt_ph = '0;
                trig   = 1'b1;
            end else begin
                nxt_ph = ph_q + PH_W'(1);
            end
        end
        if (tset_valid) begin
            nxt_sec = tset_sec;
        end
    end

    // Counter and edge-detector registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pps_q <= 1'b0;
            sec_q <= '0;
            smp_q <= '0;
            ph_q  <= '0;
        end else begin
            pps_q <= pps;
            sec_q <= nxt_sec;
            smp_q <= nxt_smp;
            ph_q  <= nxt_ph;
        end
    end
endmodule

// File: rtl/sphx_byte_mux.sv
`timescale 1ns/1ps
// Selects one packet byte from a held snapshot: sync, fields MSB first,
// then an XOR checksum over all preceding bytes. Purely combinational.
module sphx_byte_mux
    import sphx_pkg::*;
#(
    localparam int IDX_W = $clog2(PKT_BYTES)
) (
    input  snap_t            snap,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_out
);
    logic [8*BODY_BYTES-1:0] body;
    logic [7:0]              bytes [PKT_BYTES];
    logic [7:0]              csum;

    assign body = {SYNC_BYTE, snap};

    for (genvar gi = 0; gi < BODY_BYTES; gi++) begin : g_split
        assign bytes[gi] = body[8*(BODY_BYTES-1-gi) +: 8];
    end
    assign bytes[BODY_BYTES] = csum;

    // XOR of every body byte
    always_comb begin
        csum = '0;
        for (int i = 0; i < BODY_BYTES; i++) begin
            csum = csum ^ body[8*i +: 8];
        end
    end

    // Byte selection by position
    always_comb begin
        byte_out = '0;
        for (int i = 0; i < PKT_BYTES; i++) begin
            if (idx == IDX_W'(i)) byte_out = bytes[i];
        end
    end
endmodule

// File: rtl/sphx_framer.sv
`timescale 1ns/1ps
// Holds a snapshot on a trigger and walks it out byte by byte over a
// valid/ready stream. A trigger while busy is dropped and sets a sticky
// overrun flag. Assumes the trigger is at most one cycle wide.
module sphx_framer
    import sphx_pkg::*;
#(
    localparam int IDX_W = $clog2(PKT_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig,
    input  snap_t      snap_in,
    input  logic       tx_ready,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    output logic       overrun
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PKT_BYTES - 1);

    snap_t            snap_q;
    logic [IDX_W-1:0] idx_q;
    logic             busy_q;
    logic             ovr_q;

    // Packet sequencing, snapshot capture and overrun tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (busy_q && tx_ready) begin
                if (idx_q == IDX_LAST) busy_q <= 1'b0;
                else                   idx_q  <= idx_q + IDX_W'(1);
            end
            if (trig) begin
                if (busy_q) begin
                    ovr_q <= 1'b1;
                end else begin
                    snap_q <= snap_in;
                    idx_q  <= '0;
                    busy_q <= 1'b1;
                end
            end
        end
    end

    sphx_byte_mux u_mux (
        .snap     (snap_q),
        .idx      (idx_q),
        .byte_out (tx_data)
    );

    assign tx_valid = busy_q;
    assign overrun  = ovr_q;
endmodule

// File: rtl/phasor_pkt_framer.sv
`timescale 1ns/1ps
// Top: time-stamped phasor packet framer. Counts samples within each
// second, keeps a loadable seconds count and emits PKT_PER_SEC packets
// per second on a byte stream. Assumes pps and smp_stb are synchronous.
module phasor_pkt_framer
    import sphx_pkg::*;
#(
    parameter int SMP_PER_SEC = 720,
    parameter int PKT_PER_SEC = 12,
    localparam int CNT_W = $clog2(SMP_PER_SEC)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pps,
    input  logic        smp_stb,
    input  logic        tset_valid,
    input  logic [31:0] tset_sec,
    input  logic [15:0] ph_re,
    input  logic [15:0] ph_im,
    input  logic [15:0] freq_in,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic        overrun
);
    logic             pps_edge;
    logic             trig;
    logic [31:0]      nxt_sec;
    logic [CNT_W-1:0] nxt_smp;
    logic [31:0]      sec_q;
    logic [CNT_W-1:0] smp_q;
    snap_t            snap_in;

    sphx_time_base #(
        .SMP_PER_SEC (SMP_PER_SEC),
        .PKT_PER_SEC (PKT_PER_SEC)
    ) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pps        (pps),
        .smp_stb    (smp_stb),
        .tset_valid (tset_valid),
        .tset_sec   (tset_sec),
        .pps_edge   (pps_edge),
        .trig       (trig),
        .nxt_sec    (nxt_sec),
        .nxt_smp    (nxt_smp),
        .sec_q      (sec_q),
        .smp_q      (smp_q)
    );

    // Snapshot assembled from the counters' next values and live inputs
    always_comb begin
        snap_in.sec  = nxt_sec;
        snap_in.smp  = FLD_W'(nxt_smp);
        snap_in.re   = ph_re;
        snap_in.im   = ph_im;
        snap_in.freq = freq_in;
    end

    sphx_framer u_fr (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .snap_in  (snap_in),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .overrun  (overrun)
    );
endmodule

// File: rtl/phasor_pkt_framer_chk.sv
`timescale 1ns/1ps
// Property checker for phasor_pkt_framer, attached by bind below.
module phasor_pkt_framer_chk #(
    parameter int SMP_PER_SEC = 720,
    localparam int CNT_W = $clog2(SMP_PER_SEC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pps_edge,
    input logic             tset_valid,
    input logic [31:0]      tset_sec,
    input logic [31:0]      sec_q,
    input logic [CNT_W-1:0] smp_q,
    input logic [7:0]       tx_data,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             overrun
);
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!tx_valid && !overrun)); // R1
    AST_PPS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) pps_edge |=> (smp_q == '0)); // R2
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (pps_edge && !tset_valid) |=> (sec_q == $past(sec_q) + 32'd1)); // R2
    AST_SEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n) tset_valid |=> (sec_q == $past(tset_sec))); // R5
    AST_SMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n) smp_q < CNT_W'(SMP_PER_SEC)); // R4
    AST_SYNC_LEAD: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_valid) |-> (tx_data == 8'hA5)); // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R9
endmodule

bind phasor_pkt_framer phasor_pkt_framer_chk #(.SMP_PER_SEC(SMP_PER_SEC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pps_edge   (pps_edge),
    .tset_valid (tset_valid),
    .tset_sec   (tset_sec),
    .sec_q      (sec_q),
    .smp_q      (smp_q),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .overrun    (overrun)
);

// File: tb/phasor_pkt_framer_test.sv
`timescale 1ns/1ps
module phasor_pkt_framer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pps = 1'b0;
    logic        smp_stb = 1'b0;
    logic        tset_valid = 1'b0;
    logic [31:0] tset_sec = '0;
    logic [15:0] ph_re = 16'h1234;
    logic [15:0] ph_im = 16'hBEEF;
    logic [15:0] freq_in = 16'hEA60;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic        overrun;

    int errors = 0;
    int checks = 0;
    logic [7:0] cap [$];

    always #2.5 clk = ~clk;

    phasor_pkt_framer uut (
        .clk(clk), .rst_n(rst_n), .pps(pps), .smp_stb(smp_stb),
        .tset_valid(tset_valid), .tset_sec(tset_sec),
        .ph_re(ph_re), .ph_im(ph_im), .freq_in(freq_in),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .overrun(overrun)
    );

    // Capture every handshaken byte, sampled midway between edges
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) cap.push_back(tx_data);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; pps = 1'b0; smp_stb = 1'b0; tset_valid = 1'b0; tx_ready = 1'b1;
        tick(3);
        rst_n = 1'b1;
        cap.delete();
    endtask

    task automatic pps_pulse(input logic with_stb);
        pps = 1'b1; smp_stb = with_stb;
        tick(1);
        smp_stb = 1'b0;
        tick(2);
        pps = 1'b0;
        tick(1);
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            smp_stb = 1'b1; tick(1);
            smp_stb = 1'b0; tick(1);
        end
    endtask

    // Compare one 14-byte packet in the capture at position base
    task automatic chk_pkt(input string req, input int base, input logic [31:0] sec,
                           input logic [15:0] smp, input logic [15:0] re,
                           input logic [15:0] im, input logic [15:0] fr);
        logic [7:0] e [14];
        logic [7:0] x;
        e[0] = 8'hA5;
        e[1] = sec[31:24]; e[2] = sec[23:16]; e[3] = sec[15:8]; e[4] = sec[7:0];
        e[5] = smp[15:8];  e[6] = smp[7:0];
        e[7] = re[15:8];   e[8] = re[7:0];
        e[9] = im[15:8];   e[10] = im[7:0];
        e[11] = fr[15:8];  e[12] = fr[7:0];
        x = '0;
        for (int i = 0; i < 13; i++) x = x ^ e[i];
        e[13] = x;
        for (int i = 0; i < 14; i++) begin
            if (base + i < cap.size()) chk(req, {24'd0, cap[base + i]}, {24'd0, e[i]});
            else chk(req, 32'hFFFF_FFFF, {24'd0, e[i]});
        end
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 tx_valid after reset", {31'd0, tx_valid}, 32'd0);
        chk("R1 overrun after reset", {31'd0, overrun}, 32'd0);
        tick(5);
        chk("R1 no bytes while idle", cap.size(), 32'd0);
    endtask

    task automatic t_pps_packet();
        do_reset();
        pps = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R2 valid one cycle after edge", {31'd0, tx_valid}, 32'd1);
        chk("R6 sync byte first", {24'd0, tx_data}, 32'h0000_00A5);
        tick(30);
        chk("R2 level pps gives one packet", cap.size(), 32'd14);
        chk_pkt("R6 packet after first pps", 0, 32'd1, 16'd0, 16'h1234, 16'hBEEF, 16'hEA60);
        pps = 1'b0;
        tick(2);
    endtask

    task automatic t_samples();
        do_reset();
        pps_pulse(1'b0);
        tick(20);
        cap.delete();
        strobes(59);
        tick(5);
        chk("R3 no packet before 60th sample", cap.size(), 32'd0);
        strobes(1);
        tick(20);
        chk_pkt("R3 packet at sample 60", 0, 32'd1, 16'd60, 16'h1234, 16'hBEEF, 16'hEA60);
        strobes(659);
        tick(20);
        chk("R3 eleven packets within second", cap.size(), 32'd154);
        for (int k = 0; k < 11; k++) begin
            chk("R3 sample field", {16'd0, cap[14*k + 5], cap[14*k + 6]}, 32'(60 * (k + 1)));
        end
        strobes(70);
        tick(20);
        chk("R4 no packet past 719", cap.size(), 32'd154);
        cap.delete();
        pps_pulse(1'b0);
        tick(20);
        chk_pkt("R2 next second packet", 0, 32'd2, 16'd0, 16'h1234, 16'hBEEF, 16'hEA60);
    endtask

    task automatic t_load();
        do_reset();
        tset_sec = 32'h1234_5678; tset_valid = 1'b1;
        tick(1);
        tset_valid = 1'b0;
        tick(20);
        chk("R5 load starts no packet", cap.size(), 32'd0);
        pps_pulse(1'b0);
        tick(20);
        chk_pkt("R5 increment from loaded", 0, 32'h1234_5679, 16'd0, 16'h1234, 16'hBEEF, 16'hEA60);
        cap.delete();
        tset_sec = 32'hCAFE_0000; tset_valid = 1'b1; pps = 1'b1;
        tick(1);
        tset_valid = 1'b0;
        tick(2);
        pps = 1'b0;
        tick(20);
        chk_pkt("R5 load beats pps increment", 0, 32'hCAFE_0000, 16'd0, 16'h1234, 16'hBEEF, 16'hEA60);
    endtask

    task automatic t_stall();
        do_reset();
        tx_ready = 1'b0;
        pps_pulse(1'b0);
        ph_re = 16'h0BAD; ph_im = 16'hF00D; freq_in = 16'h7777;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R8 valid held while stalled", {31'd0, tx_valid}, 32'd1);
            chk("R8 data held while stalled", {24'd0, tx_data}, 32'h0000_00A5);
        end
        tick(1);
        tx_ready = 1'b1;
        tick(20);
        chk_pkt("R7 snapshot taken at trigger", 0, 32'd1, 16'd0, 16'h1234, 16'hBEEF, 16'hEA60);
        ph_re = 16'h1234; ph_im = 16'hBEEF; freq_in = 16'hEA60;
    endtask

    task automatic t_overrun();
        do_reset();
        tx_ready = 1'b0;
        pps_pulse(1'b0);
        strobes(60);
        @(negedge clk);
        chk("R9 overrun set on collision", {31'd0, overrun}, 32'd1);
        tick(1);
        tx_ready = 1'b1;
        tick(30);
        chk("R9 dropped packet not sent", cap.size(), 32'd14);
        chk("R9 surviving packet is older", {16'd0, cap[5], cap[6]}, 32'd0);
        strobes(60);
        tick(20);
        chk("R9 overrun stays set", {31'd0, overrun}, 32'd1);
        chk("R9 later packet still sent", cap.size(), 32'd28);
        do_reset();
        @(negedge clk);
        chk("R1 reset clears overrun", {31'd0, overrun}, 32'd0);
    endtask

    task automatic t_coincide();
        do_reset();
        pps_pulse(1'b1);
        tick(20);
        chk_pkt("R10 strobe absorbed by edge", 0, 32'd1, 16'd0, 16'h1234, 16'hBEEF, 16'hEA60);
        cap.delete();
        strobes(60);
        tick(20);
        chk("R10 next packet at sample 60", {16'd0, cap[5], cap[6]}, 32'd60);
    endtask

    initial begin
        #750000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_pps_packet();
        t_samples();
        t_load();
        t_stall();
        t_overrun();
        t_coincide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule